// File: doc/BRIEF.md
# Clocked Serial Shift Controller

This block is the synchronous serial port of a small 4-bit controller. An 8-bit shift register, which the host reads and writes as two 4-bit halves, sends its contents least significant bit first on the serial output and takes in a byte from the serial input at the same time. The transmit clock is either generated inside the block from a selectable divider or taken from the clock pin. A 3-bit counter tracks the clocks of a byte.

A three-state sequencer (start-wait, clock-wait, transfer) governs each byte. The host arms the port with a start strobe. The first falling clock edge begins the transfer, and the eighth rising edge ends it and raises a sticky interrupt request flag. Clock edges that arrive after a byte has finished start a new transfer without any report. A later write to the mode register makes such an overrun visible, because a mode write that cuts a transfer short raises the flag. The only exception is a cut that lands in the first low phase of the clock.

The mode register is write-only and takes effect with a two-cycle delay. Its encoding is bit 0 for clock-pin enable, bit 1 for internal clock source, and bits 3:2 for the divider select.

Top module: `sio_shift_ctrl`

## Requirements
- R1: After reset the flag reads 0, both data halves read 0, `sdo` is 1, `sck_out` is 1 and `sck_oe` is 0.
- R2: During a transfer `sdo` presents the register bits from bit 0 upward, changing after each falling clock edge. Each rising edge shifts the register right and loads `sdi` into bit 7. After eight clocks the received byte reads back as `data_lo` (bits 3:0) and `data_hi` (bits 7:4). Host half-writes are readable back directly.
- R3: The eighth rising edge of a transfer sets the flag and returns the sequencer to clock-wait. The bit counter reads zero in every state other than transfer.
- R4: In clock-wait, a falling edge re-enters transfer without setting the flag. A following mode write then sets the flag.
- R5: A mode write moves the sequencer to start-wait, clears the bit counter and blocks further clock edges from the shift register. If the sequencer was in transfer past its first low phase, the write also sets the flag.
- R6: A mode write or a start strobe that arrives while the transfer is still in its first low clock phase leaves the flag unchanged.
- R7: A start strobe during transfer sets the flag and returns the sequencer to clock-wait with the counter at zero, so a full eight further clocks are needed for the next completion.
- R8: A mode value written in cycle n governs start strobes from cycle n+2 on. A strobe in cycle n+1 still uses the previous value.
- R9: With mode bits 1:0 = 11, `sck_oe` is 1. A start strobe makes `sck_out` produce 16 half-periods of 2^sel cycles each, sel being mode bits 3:2, starting with a low half. `sck_out` rests high.
- R10: With mode bit 0 = 0, `sck_in` is ignored: no transfer advances, the data and flag stay unchanged, and `sck_oe` is 0.
- R11: The flag holds until `flag_clr`. A set event in the same cycle as `flag_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode value: [0] pin enable, [1] internal clock, [3:2] divider select |
| lo_we | input | 1 | Write strobe for data bits 3:0 |
| hi_we | input | 1 | Write strobe for data bits 7:4 |
| half_wdata | input | 4 | Data for a half write |
| data_lo | output | 4 | Shift register bits 3:0 |
| data_hi | output | 4 | Shift register bits 7:4 |
| start | input | 1 | Start-transfer command strobe |
| flag_clr | input | 1 | Interrupt flag clear |
| sck_in | input | 1 | Clock pin level (external source) |
| sck_out | output | 1 | Generated clock for the pin |
| sck_oe | output | 1 | Clock pin drive enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq_flag | output | 1 | Serial interrupt request flag |

## Verification
The host's flag clear and the completion of a byte on its eighth rising edge can fall in the same cycle. The bench provokes this by leaving the flag set from a prior byte. It then drives the final rising pin edge so that `flag_clr` is high in exactly the cycle the synchronised edge is detected. The flag must still read 1 afterwards and must drop on a later lone clear. A mode write landing on the cycle a clock edge is detected is judged the same way: the register contents must stay frozen.

// File: rtl/sio_shift_ctrl.sv
`timescale 1ns/1ps
module sio_shift_ctrl #(
  parameter int HALF_W = 4,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [3:0]        mode_wdata,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [HALF_W-1:0] half_wdata,
  output logic [HALF_W-1:0] data_lo,
  output logic [HALF_W-1:0] data_hi,
  input  logic              start,
  input  logic              flag_clr,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              irq_flag
);
  localparam int DATA_W = 2 * HALF_W;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int HALVES = 2 * DATA_W;
  localparam int HV_W   = $clog2(HALVES + 1);

  typedef enum logic [1:0] {ST_SW = 2'd0, ST_CW = 2'd1, ST_XF = 2'd2} seq_t;

  seq_t              state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [3:0]        mode_pend, mode_act;
  logic              pend_v;
  logic              sck_sync, sck_prev, sdo_q, gen_clk;
  logic [HV_W-1:0]   gen_left;
  logic [DIV_W-1:0]  div_cnt;

  wire              pin_en  = mode_act[0];
  wire              int_src = mode_act[1];
  wire [DIV_W-1:0]  div_lim = DIV_W'((1 << mode_act[3:2]) - 1);
  wire              sck_lvl = !pin_en ? 1'b1 : (int_src ? gen_clk : sck_sync);
  wire              rise    = sck_lvl & ~sck_prev;
  wire              fall    = ~sck_lvl & sck_prev;
  wire              cmd     = mode_we | start;
  wire              in_xf   = (state == ST_XF);
  wire              first_low = in_xf && (cnt == '0);
  wire              done    = in_xf && rise && (cnt == CNT_W'(DATA_W - 1));
  wire              cut_set = in_xf && !first_low && cmd;
  wire              shift_en = !cmd && in_xf && rise;
  wire              out_en  = !cmd && fall && (state != ST_SW);
  wire              start_gen = start && !mode_we && pin_en && int_src;

  logic [DATA_W-1:0] sh_next;
  always_comb begin
    sh_next = shift_en ? {sdi, shreg[DATA_W-1:1]} : shreg;
    if (lo_we) sh_next[HALF_W-1:0] = half_wdata;
    if (hi_we) sh_next[DATA_W-1:HALF_W] = half_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_pend <= '0;
      mode_act  <= '0;
      pend_v    <= 1'b0;
    end else begin
      pend_v <= mode_we;
      if (mode_we) mode_pend <= mode_wdata;
      if (pend_v)  mode_act  <= mode_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_SW;
      cnt   <= '0;
    end else if (mode_we) begin
      state <= ST_SW;
      cnt   <= '0;
    end else if (start) begin
      state <= ST_CW;
      cnt   <= '0;
    end else begin
      case (state)
        ST_CW: if (fall) state <= ST_XF;
        ST_XF: if (rise) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(DATA_W - 1)) state <= ST_CW;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      sdo_q    <= 1'b1;
      sck_sync <= 1'b1;
      sck_prev <= 1'b1;
      irq_flag <= 1'b0;
    end else begin
      shreg    <= sh_next;
      sck_sync <= sck_in;
      sck_prev <= sck_lvl;
      if (out_en) sdo_q <= shreg[0];
      if (done || cut_set) irq_flag <= 1'b1;
      else if (flag_clr)   irq_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_we) begin
      gen_clk  <= 1'b1;
      gen_left <= '0;
      div_cnt  <= '0;
    end else if (start_gen) begin
      gen_clk  <= 1'b1;
      gen_left <= HV_W'(HALVES);
      div_cnt  <= '0;
    end else if (gen_left != '0) begin
      if (div_cnt == div_lim) begin
        div_cnt  <= '0;
        gen_clk  <= ~gen_clk;
        gen_left <= gen_left - 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign data_lo = shreg[HALF_W-1:0];
  assign data_hi = shreg[DATA_W-1:HALF_W];
  assign sdo     = sdo_q;
  assign sck_out = gen_clk;
  assign sck_oe  = pin_en & int_src;
endmodule

// File: rtl/sio_shift_chk.sv
`timescale 1ns/1ps
module sio_shift_chk #(
  parameter int CNT_W = 3,
  parameter int HV_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_we,
  input logic             start,
  input logic             flag_clr,
  input logic             irq_flag,
  input logic             sck_out,
  input logic [1:0]       state,
  input logic [CNT_W-1:0] cnt,
  input logic [HV_W-1:0]  gen_left,
  input logic             pend_v,
  input logic [3:0]       mode_act
);
  p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !flag_clr |=> irq_flag);

  p_write_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (state == 2'd0) && (cnt == '0));

  p_cut_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2) && (cnt != '0) && mode_we |=> irq_flag);

  p_first_low_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2) && (cnt == '0) && (mode_we || start) && !irq_flag |=> !irq_flag);

  p_cnt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd2) |-> (cnt == '0));

  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_left == '0) |-> sck_out);

  p_apply_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we && !pend_v |=> $stable(mode_act));
endmodule

bind sio_shift_ctrl sio_shift_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .start(start),
  .flag_clr(flag_clr), .irq_flag(irq_flag), .sck_out(sck_out),
  .state(state), .cnt(cnt), .gen_left(gen_left), .pend_v(pend_v),
  .mode_act(mode_act)
);

// File: tb/sio_shift_ctrl_test.sv
`timescale 1ns/1ps
module sio_shift_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0, start = 1'b0, flag_clr = 1'b0;
  logic [3:0] mode_wdata = '0, half_wdata = '0;
  logic sck_in = 1'b1, sdi = 1'b0;
  logic [3:0] data_lo, data_hi;
  logic sck_out, sck_oe, sdo, irq_flag;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sio_shift_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .lo_we(lo_we), .hi_we(hi_we), .half_wdata(half_wdata),
    .data_lo(data_lo), .data_hi(data_hi), .start(start), .flag_clr(flag_clr),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdi(sdi), .sdo(sdo), .irq_flag(irq_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [3:0] v);
    mode_wdata = v; mode_we = 1'b1; tick(1); mode_we = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    half_wdata = v[3:0]; lo_we = 1'b1; tick(1); lo_we = 1'b0;
    half_wdata = v[7:4]; hi_we = 1'b1; tick(1); hi_we = 1'b0;
  endtask

  task automatic go;
    start = 1'b1; tick(1); start = 1'b0;
  endtask

  task automatic clr;
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic pulse(input logic d);
    sck_in = 1'b0; sdi = d; tick(3); sck_in = 1'b1; tick(3);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog all-requirements act=timeout exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    chk("R1 flag", irq_flag, 0);
    chk("R1 lo", data_lo, 0);
    chk("R1 hi", data_hi, 0);
    chk("R1 sdo", sdo, 1);
    chk("R1 sck_out", sck_out, 1);
    chk("R1 sck_oe", sck_oe, 0);

    wr_mode(4'b0001); tick(2);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] tx, rx;
      tx = 8'(i * 37 + 5);
      rx = 8'(i * 91 + 200);
      load(tx);
      chk("R2 readback", {data_hi, data_lo}, tx);
      go;
      for (int b = 0; b < 8; b++) begin
        sck_in = 1'b0; sdi = rx[b]; tick(3);
        chk("R2 sdo bit", sdo, tx[b]);
        if (b == 7) chk("R3 not early", irq_flag, 0);
        sck_in = 1'b1; tick(3);
      end
      chk("R3 done flag", irq_flag, 1);
      chk("R2 rx lo", data_lo, rx[3:0]);
      chk("R2 rx hi", data_hi, rx[7:4]);
      tick(5);
      chk("R11 held", irq_flag, 1);
      clr;
      chk("R11 cleared", irq_flag, 0);
    end

    // R4 overrun: extra clock silently restarts, mode write exposes it
    pulse(1'b0);
    chk("R4 silent", irq_flag, 0);
    wr_mode(4'b0001);
    chk("R4 exposed", irq_flag, 1);
    clr; tick(2);

    // R5 write mid-transfer freezes the register
    load(8'hA5); go;
    for (int k = 0; k < 3; k++) pulse(1'b0);
    wr_mode(4'b0001);
    chk("R5 flag", irq_flag, 1);
    for (int k = 0; k < 2; k++) pulse(1'b1);
    chk("R5 frozen", {data_hi, data_lo}, 8'h14);
    clr; tick(2);

    // R6 first low phase: write then start
    go; sck_in = 1'b0; tick(3);
    wr_mode(4'b0001);
    chk("R6 write quiet", irq_flag, 0);
    sck_in = 1'b1; tick(3);
    go; sck_in = 1'b0; tick(3);
    go;
    chk("R6 start quiet", irq_flag, 0);
    sck_in = 1'b1; tick(3);
    wr_mode(4'b0001); tick(2);

    // R7 start during transfer restarts count
    go; pulse(1'b0); pulse(1'b0);
    go;
    chk("R7 flag", irq_flag, 1);
    clr;
    for (int k = 0; k < 7; k++) pulse(1'b0);
    chk("R7 seven", irq_flag, 0);
    pulse(1'b0);
    chk("R7 eight", irq_flag, 1);

    // R11 set beats clear: flag still set, collide clear with 8th edge
    go;
    for (int k = 0; k < 7; k++) pulse(1'b1);
    sck_in = 1'b0; tick(3);
    sck_in = 1'b1; tick(1);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk("R11 set wins", irq_flag, 1);
    chk("R11 data", {data_hi, data_lo}, 8'hFF);
    clr;
    chk("R11 later clear", irq_flag, 0);

    // R10 pin disabled
    wr_mode(4'b0000); tick(2);
    load(8'h3C); go;
    for (int k = 0; k < 8; k++) pulse(1'b1);
    chk("R10 flag", irq_flag, 0);
    chk("R10 data", {data_hi, data_lo}, 8'h3C);
    chk("R10 oe", sck_oe, 0);

    // R8 start one cycle after write uses old (disabled) setting
    wr_mode(4'b0011);
    go;
    tick(60);
    chk("R8 old mode", irq_flag, 0);
    chk("R8 no clock", sck_out, 1);
    chk("R9 oe", sck_oe, 1);

    // R9 internal clock, sel 0
    load(8'h00); sdi = 1'b1; go;
    tick(40);
    chk("R9 sel0 flag", irq_flag, 1);
    chk("R9 sel0 data", {data_hi, data_lo}, 8'hFF);
    chk("R9 idle high", sck_out, 1);
    clr;

    // R9 internal clock, sel 2: half-period 4 cycles
    wr_mode(4'b1011); tick(2);
    load(8'h5A); sdi = 1'b0; go;
    tick(5);
    chk("R9 first half low", sck_out, 0);
    tick(4);
    chk("R9 second half high", sck_out, 1);
    tick(49);
    chk("R9 not yet", irq_flag, 0);
    tick(10);
    chk("R9 sel2 flag", irq_flag, 1);
    chk("R9 sel2 data", {data_hi, data_lo}, 8'h00);
    chk("R9 rest high", sck_out, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule